// File: doc/BRIEF.md
# Sampling Converter Serial Output Logic

This block is the digital output stage of a 16-bit sampling converter. It runs on one system clock. A stub conversion engine provides the conversion result. A counter stands in for the conversion time. The block detects a conversion request and drives an active-high ready flag that drops for the conversion window. Inside that window it moves the new result into the output register.

The serial data line is driven in one of two ways, selected by a clock-source input:

- **Internal clock mode.** The block generates its own 16-pulse data clock. It streams the result of the previous conversion while the current conversion runs. After the last pulse it parks the line at a latched tag level, so several converters can be chained.
- **External clock mode.** The host clocks bits out of the output register. A read can happen after a conversion finishes, or while the next conversion is still running. If the register is reloaded while a read is open and the external clock is high, the result is lost. The block flags this with a hazard output.

The low-byte parallel enable is also produced here. The serial line itself is never tri-stated.

Top module: `conv_serial_out`

## Requirements
- R1: After reset, rdy_o is 1, dclk_o is 0, sdata_o is 0, hazard_o is 0 and the output register holds zero.
- R2: A conversion starts on a clock edge where cs_ni is 0, rc_i is 0 and rdy_o is 1. rdy_o is 0 from the next cycle for exactly CONV_CYC cycles and then returns to 1. A request that arrives while rdy_o is 0 is ignored and does not extend the window.
- R3: In internal mode (ext_sel_i = 0), a start produces exactly DATA_W pulses on dclk_o.
  - dclk_o first rises HALF cycles after the start edge.
  - Each pulse is HALF cycles high followed by HALF cycles low.
  - After the last falling edge, dclk_o stays 0 until the next start.
- R4: In internal mode, sdata_o carries the result of the previous conversion, most significant bit first. Bit k is valid while pulse k+1 is high. Before the first conversion, the previous result reads as zero.
- R5: In internal mode, after the last pulse sdata_o holds the tag_i level sampled on the first rising edge of dclk_o. Later changes of tag_i do not alter it.
- R6: In external mode (ext_sel_i = 1), the output register is loaded with result_i on the edge LOAD_AT+1 cycles after the start, and sdata_o then shows its MSB.
  - Each rising edge of xclk_i seen while cs_ni = 0 and rc_i = 1 advances sdata_o by one bit.
  - Rising edges of xclk_i while the output is disabled have no effect.
  - The previous result can be read out while the next conversion runs, up to that conversion's load edge.
- R7: In external mode, if at the load edge cs_ni = 0, rc_i = 1 and xclk_i = 1, the load is dropped: the output register keeps its old content and hazard_o becomes 1. hazard_o stays 1 until the next start, which clears it.
- R8: lo_oe_o is 1 exactly when cs_ni = 0 and rc_i = 1, in both modes.
- R9: In external mode, dclk_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read (1) / convert (0) strobe |
| ext_sel_i | input | 1 | Data clock source: 0 internal, 1 external |
| tag_i | input | 1 | Daisy-chain tag input |
| xclk_i | input | 1 | External data clock, sampled on clk_i |
| result_i | input | DATA_W | Result from the conversion engine stub |
| rdy_o | output | 1 | High when no conversion is running |
| sdata_o | output | 1 | Serial data, MSB first |
| dclk_o | output | 1 | Internally generated data clock |
| lo_oe_o | output | 1 | Enable for the low-byte parallel outputs |
| hazard_o | output | 1 | Reload-during-read data loss flag |

## Verification
The hardest case to reach is the reload hazard. The external clock must be held high, with the output enabled, exactly across the hidden load edge. It must also reach that high level without producing a rising edge that would shift the register. The bench raises xclk_i while chip select is still high, then opens the read and holds it through the load. It loads a known word beforehand and offers the bitwise inverse as the new result, so a dropped load shows up on every bit when the register is clocked out.

The bench also clocks out one word while the next conversion is still running. This shows that the data age differs between external and internal modes.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   // counter width that holds values 0..n-1, never narrower than one bit
   function automatic int unsigned cnt_w(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sop_conv_timer.sv
module sop_conv_timer
   import sop_pkg::*;
#(
   parameter int unsigned CONV_CYC = 80,
   parameter int unsigned LOAD_AT  = 60
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic load_o
);

   localparam int unsigned CW = cnt_w(CONV_CYC);

   generate
      if (CONV_CYC < 3) begin : g_bad_len
         $error("sop_conv_timer: CONV_CYC must be at least 3");
      end
      if (LOAD_AT + 1 >= CONV_CYC) begin : g_bad_load
         $error("sop_conv_timer: load point must precede the end of the window");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + CW'(1);
         if (cnt_q == CW'(CONV_CYC - 1)) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign load_o = busy_q && (cnt_q == CW'(LOAD_AT));

   // R2: the window ends only after the full count
   a_r2_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q) |-> $past(cnt_q) == CW'(CONV_CYC - 1));

   // R2: a start always opens the window on the next cycle
   a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o);

endmodule

// File: rtl/sop_int_clk.sv
module sop_int_clk
   import sop_pkg::*;
#(
   parameter int unsigned HALF   = 2,
   parameter int unsigned PULSES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic dclk_o,
   output logic rise_o,
   output logic fall_o,
   output logic first_o
);

   localparam int unsigned TW = cnt_w(HALF);
   localparam int unsigned PW = cnt_w(PULSES + 1);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("sop_int_clk: HALF must be at least 1");
      end
      if (PULSES < 1) begin : g_bad_pulses
         $error("sop_int_clk: PULSES must be at least 1");
      end
   endgenerate

   logic          run_q;
   logic          dclk_q;
   logic [TW-1:0] tcnt_q;
   logic [PW-1:0] pcnt_q;
   logic          edge_w;

   assign edge_w  = run_q && (tcnt_q == TW'(HALF - 1));
   assign rise_o  = edge_w && !dclk_q;
   assign fall_o  = edge_w && dclk_q;
   assign first_o = rise_o && (pcnt_q == '0);
   assign dclk_o  = dclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         dclk_q <= 1'b0;
         tcnt_q <= '0;
         pcnt_q <= '0;
      end else if (start_i) begin
         run_q  <= 1'b1;
         dclk_q <= 1'b0;
         tcnt_q <= '0;
         pcnt_q <= '0;
      end else if (run_q) begin
         if (edge_w) begin
            tcnt_q <= '0;
            dclk_q <= !dclk_q;
            if (dclk_q) begin
               pcnt_q <= pcnt_q + PW'(1);
               if (pcnt_q == PW'(PULSES - 1)) run_q <= 1'b0;
            end
         end else begin
            tcnt_q <= tcnt_q + TW'(1);
         end
      end
   end

   // R3: the clock rests low whenever the generator is idle
   a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> !dclk_q);

   // R3: the burst stops only after the final pulse
   a_r3_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_q) |-> $past(pcnt_q) == PW'(PULSES - 1));

endmodule

// File: rtl/sop_shifter.sv
module sop_shifter #(
   parameter int unsigned DATA_W = 16,
   parameter bit          DAISY  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              shift_i,
   input  logic              shin_i,
   output logic              msb_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sop_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sh_q;
   logic              fill_w;

   generate
      if (DAISY) begin : g_chain
         assign fill_w = shin_i;
      end else begin : g_zero
         assign fill_w = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (load_i)  sh_q <= load_val_i;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], fill_w};
   end

   assign msb_o = sh_q[DATA_W-1];

   // R6: one shift moves the next bit to the line
   a_r6_shift_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> msb_o == $past(sh_q[DATA_W-2]));

endmodule

// File: rtl/conv_serial_out.sv
module conv_serial_out
   import sop_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CONV_CYC = 80,
   parameter int unsigned LOAD_AT  = 60,
   parameter int unsigned HALF     = 2,
   parameter bit          DAISY    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_ni,
   input  logic              rc_i,
   input  logic              ext_sel_i,
   input  logic              tag_i,
   input  logic              xclk_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              rdy_o,
   output logic              sdata_o,
   output logic              dclk_o,
   output logic              lo_oe_o,
   output logic              hazard_o
);

   clk_src_e          src_w;
   logic              busy_w, load_w, start_w, start_int_w;
   logic              oe_w, xrise_w, haz_det_w, load_ok_w;
   logic              gen_dclk_w, gen_rise_w, gen_fall_w, gen_first_w;
   logic              sh_load_w, sh_shift_w, sh_in_w;
   logic [DATA_W-1:0] sh_val_w;
   logic [DATA_W-1:0] out_q;
   logic              xclk_q, tag_q, hazard_q;

   assign src_w       = clk_src_e'(ext_sel_i);
   assign oe_w        = !cs_ni && rc_i;
   assign start_w     = !cs_ni && !rc_i && !busy_w;
   assign start_int_w = start_w && (src_w == SRC_INT);
   assign xrise_w     = xclk_i && !xclk_q;
   assign haz_det_w   = load_w && (src_w == SRC_EXT) && oe_w && xclk_i;
   assign load_ok_w   = load_w && !haz_det_w;

   sop_conv_timer #(
      .CONV_CYC (CONV_CYC),
      .LOAD_AT  (LOAD_AT)
   ) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_w),
      .busy_o  (busy_w),
      .load_o  (load_w)
   );

   sop_int_clk #(
      .HALF   (HALF),
      .PULSES (DATA_W)
   ) i_clkgen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_int_w),
      .dclk_o  (gen_dclk_w),
      .rise_o  (gen_rise_w),
      .fall_o  (gen_fall_w),
      .first_o (gen_first_w)
   );

   // held copy of the latest result, streamed on the next internal start
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q    <= '0;
         xclk_q   <= 1'b0;
         tag_q    <= 1'b0;
         hazard_q <= 1'b0;
      end else begin
         xclk_q <= xclk_i;
         if (load_ok_w)   out_q <= result_i;
         if (gen_first_w) tag_q <= tag_i;
         if (start_w)        hazard_q <= 1'b0;
         else if (haz_det_w) hazard_q <= 1'b1;
      end
   end

   always_comb begin
      sh_load_w  = 1'b0;
      sh_val_w   = out_q;
      sh_shift_w = 1'b0;
      sh_in_w    = tag_q;
      if (src_w == SRC_INT) begin
         sh_load_w  = start_int_w;
         sh_shift_w = gen_fall_w;
      end else begin
         sh_load_w  = load_ok_w;
         sh_val_w   = result_i;
         sh_shift_w = xrise_w && oe_w;
         sh_in_w    = tag_i;
      end
   end

   sop_shifter #(
      .DATA_W (DATA_W),
      .DAISY  (DAISY)
   ) i_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (sh_load_w),
      .load_val_i (sh_val_w),
      .shift_i    (sh_shift_w),
      .shin_i     (sh_in_w),
      .msb_o      (sdata_o)
   );

   assign rdy_o    = !busy_w;
   assign dclk_o   = gen_dclk_w && (src_w == SRC_INT);
   assign lo_oe_o  = oe_w;
   assign hazard_o = hazard_q;

   // R7: a detected reload hazard raises the flag
   a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      haz_det_w |=> hazard_o);

   // R7: the held result survives a hazard
   a_r7_keep_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      haz_det_w |=> $stable(out_q));

   // R5: the tag is captured only on the first internal rising edge
   a_r5_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gen_first_w && !$isunknown(tag_q)) |=> $stable(tag_q));

   // R3: a rising data clock edge only comes from the generator
   a_r3_rise_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_rise_w |=> dclk_o || src_w == SRC_EXT);

endmodule

// File: tb/test_conv_serial_out.sv
module test_conv_serial_out;

   localparam int W       = 16;
   localparam int CONV    = 80;
   localparam int LOADAT  = 60;
   localparam int H       = 2;
   localparam time CLK_P  = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1, rc = 1'b1, ext_sel = 1'b0, tag = 1'b0, xclk = 1'b0;
   logic [W-1:0] result = '0;
   logic         rdy, sdata, dclk, lo_oe, hazard;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] prev_word = '0;

   always #(CLK_P/2) clk = !clk;

   conv_serial_out #(
      .DATA_W (W), .CONV_CYC (CONV), .LOAD_AT (LOADAT), .HALF (H), .DAISY (1'b1)
   ) i_conv_serial_out (
      .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .rc_i (rc), .ext_sel_i (ext_sel),
      .tag_i (tag), .xclk_i (xclk), .result_i (result), .rdy_o (rdy), .sdata_o (sdata),
      .dclk_o (dclk), .lo_oe_o (lo_oe), .hazard_o (hazard)
   );

   function automatic logic bit_at(logic [W-1:0] v, int k);
      return v[W-1-k];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // leaves the bench at the negedge just after the start edge
   task automatic start_conv();
      @(negedge clk); cs_n = 1'b0; rc = 1'b0;
      @(negedge clk); rc = 1'b1;
   endtask

   task automatic run_int(logic [W-1:0] val, logic tg, bit poke);
      result = val; tag = tg;
      start_conv();
      chk("R2 ready drops", rdy, 0);
      for (int j = 1; j <= CONV + 1; j++) begin
         @(negedge clk);
         if (j == H + 1) tag = !tg;
         if (poke && j == 10) rc = 1'b0;
         if (poke && j == 11) rc = 1'b1;
         for (int k = 0; k < W; k++)
            if (j == (2*k + 1) * H) begin
               chk("R3 pulse high", dclk, 1);
               chk("R4 streamed bit", sdata, bit_at(prev_word, k));
            end
         if (j == 32*H + 1) begin
            chk("R3 clock parked", dclk, 0);
            chk("R5 tag level", sdata, tg);
         end
         if (j == 32*H + H + 1) chk("R3 no extra pulse", dclk, 0);
         if (j == 5) chk("R8 enable while reading", lo_oe, 1);
         if (j == CONV - 1) chk("R2 still busy", rdy, 0);
         if (j == CONV) chk("R2 ready returns", rdy, 1);
      end
      prev_word = val;
   endtask

   task automatic load_ext(logic [W-1:0] val);
      result = val;
      start_conv();
      cs_n = 1'b1;
      while (!rdy) @(negedge clk);
      chk("R7 no hazard on clean load", hazard, 0);
   endtask

   task automatic read_ext(logic [W-1:0] val);
      cs_n = 1'b0; rc = 1'b1; xclk = 1'b0;
      @(negedge clk);
      chk("R6 first bit", sdata, bit_at(val, 0));
      for (int k = 1; k < W; k++) begin
         xclk = 1'b1;
         @(negedge clk);
         chk("R6 clocked bit", sdata, bit_at(val, k));
         if (k == 1) chk("R9 no internal clock", dclk, 0);
         xclk = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [W-1:0] a, b, c, d;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 ready", rdy, 1);
      chk("R1 dclk", dclk, 0);
      chk("R1 sdata", sdata, 0);
      chk("R1 hazard", hazard, 0);
      chk("R8 idle enable", lo_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // internal mode: first stream is the reset-zero word, then random words
      run_int(16'hA5C3, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) run_int(W'($urandom), 1'($urandom), 1'b0);
      run_int(16'h0001, 1'b0, 1'b0);
      run_int(16'hFFFE, 1'b1, 1'b0);

      // external mode
      ext_sel = 1'b1;
      a = W'($urandom);
      load_ext(a);
      for (int n = 0; n < 3; n++) begin
         @(negedge clk); xclk = 1'b1;
         @(negedge clk); xclk = 1'b0;
      end
      chk("R6 disabled edges ignored", sdata, bit_at(a, 0));
      read_ext(a);

      // read the previous word while the next conversion runs
      b = W'($urandom); c = W'($urandom);
      load_ext(b);
      result = c;
      start_conv();
      chk("R6 old word during conversion", sdata, bit_at(b, 0));
      for (int k = 1; k < W; k++) begin
         xclk = 1'b1; @(negedge clk);
         chk("R6 old word bit", sdata, bit_at(b, k));
         xclk = 1'b0; @(negedge clk);
      end
      while (!rdy) @(negedge clk);
      chk("R7 no hazard with clock low", hazard, 0);
      chk("R6 new word visible", sdata, bit_at(c, 0));
      read_ext(c);

      // reload hazard: clock held high across the load edge
      d = W'($urandom);
      load_ext(d);
      @(negedge clk); xclk = 1'b1;
      result = ~d;
      start_conv();
      for (int j = 1; j <= LOADAT + 1; j++) begin
         @(negedge clk);
         if (j == LOADAT) chk("R7 flag before load", hazard, 0);
         if (j == LOADAT + 1) chk("R7 flag after load", hazard, 1);
      end
      while (!rdy) @(negedge clk);
      chk("R7 flag sticky", hazard, 1);
      @(negedge clk); xclk = 1'b0;
      read_ext(d);

      // next start clears the flag
      result = W'($urandom);
      start_conv();
      chk("R7 flag cleared by start", hazard, 0);
      cs_n = 1'b1;
      while (!rdy) @(negedge clk);
      read_ext(result);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule